// File: doc/BRIEF.md
# DRAM Size Probe Engine

This block measures how much external DRAM sits behind a memory port by relying on address wraparound. An external memory that is smaller than the address range aliases high offsets back onto low ones. The engine first writes a zero marker byte at offset 0. It then writes an index byte `i` at offset `i × 8 MiB` for `i = 1, 2, ...` and reads offset 0 back after each of those writes. The first index that shows up at offset 0 means the write to `i × 8 MiB` landed on offset 0, so the installed size is `i × 8 MiB`.

If offset 0 never changes before the index reaches one below the configured maximum divided by the step, the result is the configured maximum. A trim mode, sampled together with the start pulse, reports the result minus 1 MiB. The block does nothing else: it only sequences the probe accesses and forms the byte count.

The controller has six states:

- `PS_IDLE` waits for `start`.
- `PS_CLEAR` writes the marker.
- `PS_MARK` writes the step index.
- `PS_PEEK` reads offset 0.
- `PS_JUDGE` compares the byte read back.
- `PS_FINISH` raises `done`.

The transitions are:

- IDLE→CLEAR on start.
- CLEAR→MARK on ready.
- MARK→PEEK on ready.
- PEEK→JUDGE on ready.
- JUDGE→FINISH on a match or at the last index.
- JUDGE→MARK otherwise, with the index incremented.
- FINISH→IDLE unconditionally.

Top module: `dram_size_probe`

## Requirements
- R1: After reset `done` is 0, `mem_wr` and `mem_rd` are 0, and `size_bytes` is 0.
- R2: A `start` accepted in idle makes the first access a write of byte 0x00 to address 0.
- R3: For each index i starting at 1, the engine writes the byte value i to address i × 8 MiB (i × 2^STEP_LOG2).
- R4: Every step write is followed, on the cycle after it is accepted, by a read request of address 0.
- R5: When the byte read from address 0 equals the current index i, the result is i × 8 MiB and no further memory access is issued.
- R6: If the index reaches (2^MAX_LOG2 / 8 MiB) − 1 without a match, the result is 2^MAX_LOG2 bytes (256 MiB by default), and no write at or above that offset is made.
- R7: When `trim_mode` is 1 in the cycle `start` is accepted, the reported result is 1 MiB (2^TRIM_LOG2) less than the detected size; later changes of `trim_mode` have no effect on that probe.
- R8: A request (`mem_wr` or `mem_rd`) with its address and write data stays stable until a cycle with `mem_ready` high accepts it; `mem_wr` and `mem_rd` are never high together.
- R9: `done` is high for exactly one cycle, two cycles after the final read is accepted, and `size_bytes` changes only in that cycle and holds its value afterwards.
- R10: `start` pulses while a probe is in progress are ignored and do not disturb the access sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a probe (accepted only in idle) |
| trim_mode | input | 1 | Report result minus 1 MiB, sampled with start |
| mem_wr | output | 1 | Write request |
| mem_rd | output | 1 | Read request |
| mem_addr | output | ADDR_W | Byte address of the request |
| mem_wdata | output | DATA_W | Write byte |
| mem_rdata | input | DATA_W | Read byte, valid when a read is accepted |
| mem_ready | input | 1 | Accepts the pending request this cycle |
| done | output | 1 | One-cycle result strobe |
| size_bytes | output | MAX_LOG2+1 | Detected size in bytes |

## Verification
The hardest situation to reach is the case where no aliasing is seen. The engine must walk all the way to the last index without reading its own marker back, and it must stop without writing at the maximum offset. The bench reaches this case by modelling memories of exactly and above the maximum size, where addresses are reduced modulo the installed size. It reaches the early-exit boundary with an 8 MiB memory, where the very first step write overwrites offset 0. All cases run under several `mem_ready` stall patterns, and extra `start` pulses with a toggled `trim_mode` are injected mid-probe.

// File: rtl/probe_pkg.sv
`timescale 1ns/1ps
package probe_pkg;

    typedef enum logic [2:0] {
        PS_IDLE   = 3'd0,
        PS_CLEAR  = 3'd1,
        PS_MARK   = 3'd2,
        PS_PEEK   = 3'd3,
        PS_JUDGE  = 3'd4,
        PS_FINISH = 3'd5
    } probe_state_e;

endpackage

// File: rtl/probe_step_ctr.sv
`timescale 1ns/1ps
module probe_step_ctr #(
    parameter int IDX_W    = 5,
    parameter int LAST_IDX = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [IDX_W-1:0] idx,
    output logic             last
);

    logic [IDX_W-1:0] idx_q;

    // clr restarts the sweep at index one; the marker sits at index zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr) begin
            idx_q <= IDX_W'(1);
        end else if (inc) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign idx  = idx_q;
    assign last = (idx_q == IDX_W'(LAST_IDX));

endmodule

// File: rtl/probe_size_calc.sv
`timescale 1ns/1ps
module probe_size_calc #(
    parameter int STEP_LOG2 = 23,
    parameter int MAX_LOG2  = 28,
    parameter int TRIM_LOG2 = 20,
    parameter int IDX_W     = 5,
    parameter int SIZE_W    = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_hit,
    input  logic              load_max,
    input  logic              trim,
    input  logic [IDX_W-1:0]  idx,
    output logic [SIZE_W-1:0] size
);

    logic [SIZE_W-1:0] size_q;
    logic [SIZE_W-1:0] raw_size;
    logic [SIZE_W-1:0] trim_amt;

    always_comb begin
        if (load_max) begin
            raw_size = SIZE_W'(1) << MAX_LOG2;
        end else begin
            raw_size = SIZE_W'(idx) << STEP_LOG2;
        end
        trim_amt = trim ? (SIZE_W'(1) << TRIM_LOG2) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= '0;
        end else if (load_hit || load_max) begin
            size_q <= raw_size - trim_amt;
        end
    end

    assign size = size_q;

endmodule

// File: rtl/probe_fsm.sv
`timescale 1ns/1ps
module probe_fsm
    import probe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mem_ready,
    input  logic hit,
    input  logic last,
    output logic accept,
    output logic ctr_clr,
    output logic ctr_inc,
    output logic cap_rd,
    output logic load_hit,
    output logic load_max,
    output logic sel_step,
    output logic mem_wr,
    output logic mem_rd,
    output logic done
);

    probe_state_e state_q;
    probe_state_e state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:   if (start)     state_d = PS_CLEAR;
            PS_CLEAR:  if (mem_ready) state_d = PS_MARK;
            PS_MARK:   if (mem_ready) state_d = PS_PEEK;
            PS_PEEK:   if (mem_ready) state_d = PS_JUDGE;
            PS_JUDGE:  begin
                if (hit || last) begin
                    state_d = PS_FINISH;
                end else begin
                    state_d = PS_MARK;
                end
            end
            PS_FINISH: state_d = PS_IDLE;
            default:   state_d = PS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        accept   = 1'b0;
        ctr_clr  = 1'b0;
        ctr_inc  = 1'b0;
        cap_rd   = 1'b0;
        load_hit = 1'b0;
        load_max = 1'b0;
        sel_step = 1'b0;
        mem_wr   = 1'b0;
        mem_rd   = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            PS_IDLE: begin
                accept  = start;
                ctr_clr = start;
            end
            PS_CLEAR: begin
                mem_wr = 1'b1;
            end
            PS_MARK: begin
                mem_wr   = 1'b1;
                sel_step = 1'b1;
            end
            PS_PEEK: begin
                mem_rd = 1'b1;
                cap_rd = mem_ready;
            end
            PS_JUDGE: begin
                load_hit = hit;
                load_max = !hit && last;
                ctr_inc  = !hit && !last;
            end
            PS_FINISH: begin
                done = 1'b1;
            end
            default: begin
                done = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/dram_size_probe.sv
`timescale 1ns/1ps
module dram_size_probe #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 8,
    parameter int STEP_LOG2 = 23,
    parameter int MAX_LOG2  = 28,
    parameter int TRIM_LOG2 = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                trim_mode,
    output logic                mem_wr,
    output logic                mem_rd,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic                mem_ready,
    output logic                done,
    output logic [MAX_LOG2:0]   size_bytes
);

    localparam int IDX_W    = MAX_LOG2 - STEP_LOG2;
    localparam int NSTEPS   = 1 << IDX_W;
    localparam int LAST_IDX = NSTEPS - 1;
    localparam int SIZE_W   = MAX_LOG2 + 1;

    logic             accept;
    logic             ctr_clr;
    logic             ctr_inc;
    logic             cap_rd;
    logic             load_hit;
    logic             load_max;
    logic             sel_step;
    logic             last;
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] rd_q;
    logic             trim_q;

    probe_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mem_ready(mem_ready),
        .hit      (hit),
        .last     (last),
        .accept   (accept),
        .ctr_clr  (ctr_clr),
        .ctr_inc  (ctr_inc),
        .cap_rd   (cap_rd),
        .load_hit (load_hit),
        .load_max (load_max),
        .sel_step (sel_step),
        .mem_wr   (mem_wr),
        .mem_rd   (mem_rd),
        .done     (done)
    );

    probe_step_ctr #(
        .IDX_W   (IDX_W),
        .LAST_IDX(LAST_IDX)
    ) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ctr_clr),
        .inc  (ctr_inc),
        .idx  (idx),
        .last (last)
    );

    probe_size_calc #(
        .STEP_LOG2(STEP_LOG2),
        .MAX_LOG2 (MAX_LOG2),
        .TRIM_LOG2(TRIM_LOG2),
        .IDX_W    (IDX_W),
        .SIZE_W   (SIZE_W)
    ) u_size (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_hit(load_hit),
        .load_max(load_max),
        .trim    (trim_q),
        .idx     (idx),
        .size    (size_bytes)
    );

    // capture of the read-back byte and the trim choice
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q   <= '0;
            trim_q <= 1'b0;
        end else begin
            if (cap_rd) begin
                rd_q <= mem_rdata;
            end
            if (accept) begin
                trim_q <= trim_mode;
            end
        end
    end

    assign hit       = (rd_q == DATA_W'(idx));
    assign mem_addr  = sel_step ? (ADDR_W'(idx) << STEP_LOG2) : '0;
    assign mem_wdata = sel_step ? DATA_W'(idx) : '0;

endmodule

// File: rtl/probe_chk.sv
`timescale 1ns/1ps
module probe_chk #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 8,
    parameter int STEP_LOG2 = 23,
    parameter int TRIM_LOG2 = 20,
    parameter int SIZE_W    = 29
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_wr,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic              done,
    input logic [SIZE_W-1:0] size_bytes
);

    // R2
    marker_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_addr == '0) |-> (mem_wdata == '0));

    // R3
    step_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_addr != '0) |->
            (mem_addr[STEP_LOG2-1:0] == '0 && mem_wdata == DATA_W'(mem_addr >> STEP_LOG2)));

    // R4
    peek_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_ready && mem_addr != '0) |=> (mem_rd && mem_addr == '0));

    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    // R8
    no_dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    size_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (size_bytes != $past(size_bytes)) |-> done);

    // R5
    quiet_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_wr && !mem_rd && size_bytes[TRIM_LOG2-1:0] == '0));

endmodule

bind dram_size_probe probe_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .STEP_LOG2(STEP_LOG2),
    .TRIM_LOG2(TRIM_LOG2),
    .SIZE_W   (MAX_LOG2 + 1)
) i_probe_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_wr    (mem_wr),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .done      (done),
    .size_bytes(size_bytes)
);

// File: tb/test_dram_size_probe.sv
`timescale 1ns/1ps
module test_dram_size_probe;

    localparam longint STEP     = 64'd1 << 23;
    localparam longint MAXB     = 64'd1 << 28;
    localparam longint TRIM     = 64'd1 << 20;
    localparam int     LAST_IDX = 31;
    localparam int     LIMIT    = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        trim_mode;
    logic        mem_wr;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_ready;
    logic        done;
    logic [28:0] size_bytes;

    always #2.5 clk = ~clk;

    dram_size_probe i_dram_size_probe (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .trim_mode (trim_mode),
        .mem_wr    (mem_wr),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .done      (done),
        .size_bytes(size_bytes)
    );

    int      total = 0;
    int      bad = 0;
    int      cyc = 0;
    int      stall_mode = 0;
    int      cd = -1;
    int      probes_done = 0;
    bit      monitor_on = 0;
    longint  inst = MAXB;
    longint  exp_size = 0;
    longint  last_size = 0;
    string   exp_tag = "R5";
    int      q_kind[$];
    longint  q_addr[$];
    int      q_data[$];
    logic [7:0] mem_model [longint];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural memory and reference sequence, compared every cycle
    always @(negedge clk) begin
        if (monitor_on) begin
            bit     rdy;
            longint a;
            string  tag;
            cyc++;
            if (cyc > LIMIT) begin
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
            check(done == (cd == 0), "R9", "done strobe", longint'(done), longint'(cd == 0));
            if (cd == 0) begin
                check(longint'(size_bytes) == exp_size, exp_tag, "size",
                      longint'(size_bytes), exp_size);
                last_size = exp_size;
                probes_done++;
                cd = -1;
            end else begin
                if (cd > 0) cd--;
                check(longint'(size_bytes) == last_size, "R9", "size held",
                      longint'(size_bytes), last_size);
            end
            check(!(mem_wr && mem_rd), "R8", "wr and rd together", 1, 0);
            case (stall_mode)
                1:       rdy = cyc[0];
                2:       rdy = ((cyc * 13) % 7) < 3;
                default: rdy = 1'b1;
            endcase
            mem_ready = rdy;
            if (mem_wr || mem_rd) begin
                a = longint'(mem_addr);
                if (q_kind.size() == 0) begin
                    check(1'b0, "R5", "access after result", a, -1);
                end else begin
                    tag = (q_kind[0] == 1) ? "R4" : ((q_addr[0] == 0) ? "R2" : "R3");
                    check(int'(mem_rd) == q_kind[0], tag, "request kind",
                          longint'(mem_rd), longint'(q_kind[0]));
                    check(a == q_addr[0], tag, "address", a, q_addr[0]);
                    if (mem_wr) begin
                        check(int'(mem_wdata) == q_data[0], tag, "write byte",
                              longint'(mem_wdata), longint'(q_data[0]));
                    end
                    if (rdy) begin
                        if (mem_wr) begin
                            mem_model[a % inst] = mem_wdata;
                        end else begin
                            mem_rdata = mem_model.exists(a % inst) ? mem_model[a % inst] : 8'hA5;
                        end
                        void'(q_kind.pop_front());
                        void'(q_addr.pop_front());
                        void'(q_data.pop_front());
                        if (q_kind.size() == 0) cd = 1;
                    end
                end
            end
        end
    end

    task automatic run_probe(input longint inst_b, input bit trim, input int mode,
                             input int extra_starts, input string tag);
        int hit_idx;
        int stop_idx;
        int target;
        inst = inst_b;
        mem_model.delete();
        stall_mode = mode;
        hit_idx = (inst_b < MAXB) ? int'(inst_b / STEP) : 0;
        stop_idx = (hit_idx != 0) ? hit_idx : LAST_IDX;
        q_kind.push_back(0); q_addr.push_back(0); q_data.push_back(0);
        for (int i = 1; i <= stop_idx; i++) begin
            q_kind.push_back(0); q_addr.push_back(longint'(i) * STEP); q_data.push_back(i);
            q_kind.push_back(1); q_addr.push_back(0);                  q_data.push_back(0);
        end
        exp_size = ((hit_idx != 0) ? inst_b : MAXB) - (trim ? TRIM : 0);
        exp_tag = tag;
        target = probes_done + 1;
        @(negedge clk);
        trim_mode = trim;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R10: extra starts with a flipped trim request during the probe
        for (int k = 0; k < extra_starts; k++) begin
            repeat (4) @(negedge clk);
            start = 1'b1;
            trim_mode = ~trim;
            @(negedge clk);
            start = 1'b0;
            trim_mode = trim;
        end
        while (probes_done < target) @(negedge clk);
        check(q_kind.size() == 0, tag, "sequence complete", q_kind.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        trim_mode = 1'b0;
        mem_ready = 1'b0;
        mem_rdata = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(done == 1'b0, "R1", "done after reset", longint'(done), 0);
        check(mem_wr == 1'b0 && mem_rd == 1'b0, "R1", "request after reset",
              longint'({mem_wr, mem_rd}), 0);
        check(size_bytes == '0, "R1", "size after reset", longint'(size_bytes), 0);
        monitor_on = 1'b1;

        run_probe(STEP,        1'b0, 0, 0, "R5");
        run_probe(4 * STEP,    1'b0, 1, 0, "R5");
        run_probe(8 * STEP,    1'b1, 2, 0, "R7");
        run_probe(MAXB,        1'b0, 0, 0, "R6");
        run_probe(4 * MAXB,    1'b1, 1, 0, "R6");
        run_probe(16 * STEP,   1'b0, 2, 3, "R10");
        run_probe(2 * STEP,    1'b1, 2, 2, "R7");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule